// File: doc/BRIEF.md
# Dual-Rail Self-Timed Register Stage

This block is one register stage of a delay-insensitive pipeline that carries N bits in dual-rail form. Each bit is a pair of rails: the "one" rail high means logic 1, the "zero" rail high means logic 0, and both rails low is the empty (NULL) spacer. Pipeline operation alternates strictly between a wave of values and a wave of spacers. The stage takes a value wave only while the stage after it asks for values, and it takes a spacer wave only while that stage asks for spacers.

Every output rail is a two-input hysteresis element, also called a C-element. It joins the incoming rail with the downstream request `ki`. It goes high when both inputs are high, goes low when both are low, and otherwise keeps its state. A completion detector also has hysteresis. It watches the registered groups and drives the upstream request `ko` low once every group holds a value, and high again once every group is empty. Stages chain by wiring one stage's `ko` to the `ki` of the stage before it. The threshold elements are modelled as clocked state elements, so each one adds a cycle of latency and the block can live inside a synchronous code base.

Top module: `ncl_pipe_stage`

## Requirements
- R1: While `rst` is high, and on the first cycle after it drops, every output rail is 0 and `ko` is 1. In that state the stage holds NULL and requests values.
- R2: An output rail rises only when its input rail and `ki` were both high on the previous clock edge. It rises one cycle after that edge, so a value word on the inputs with `ki`=1 appears on the outputs one cycle later.
- R3: An output rail falls only when its input rail and `ki` were both low on the previous edge. A NULL input with `ki`=0 clears the outputs one cycle later.
- R4: When an input rail and `ki` disagree, the output rail keeps its value. A NULL input under `ki`=1 does not clear held data, and data under `ki`=0 does not enter an empty stage.
- R5: `ko` falls one cycle after the cycle in which every registered group holds exactly one high rail. `ko` stays high while any group is still NULL.
- R6: `ko` rises one cycle after the cycle in which every registered group is NULL. `ko` stays low while any group still holds a value.
- R7: Two chained stages, between a four-phase source and a sink of varying speed, deliver every word once, in order and unchanged. Their outputs alternate strictly between full value words and full NULL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the state elements |
| rst | input | 1 | Synchronous active-high reset to NULL |
| din_r0 | input | N | Zero rails of the incoming groups |
| din_r1 | input | N | One rails of the incoming groups |
| ki | input | 1 | Downstream request: 1 asks for values, 0 asks for NULL |
| dout_r0 | output | N | Registered zero rails |
| dout_r1 | output | N | Registered one rails |
| ko | output | 1 | Upstream request: 1 asks for values, 0 asks for NULL |

## Verification
The assertions check the per-rail rules on every cycle. A rail may rise only after its input and `ki` were both high, fall only after both were low, and stays put when they disagree. They also check that `ko` changes only after the registered word is complete or fully empty, and the reset state. The bench scenarios show what no single-cycle rule can. Partial words must not move `ko`. A waiting downstream stage must hold back new data. Across a two-stage chain with a slow, irregular sink, every word must arrive exactly once, in order, with a NULL wave between each pair of words.

// File: rtl/ncl_stage_pkg.sv
package ncl_stage_pkg;

    typedef enum logic [1:0] {
        GRP_EMPTY   = 2'd0,
        GRP_ZERO    = 2'd1,
        GRP_ONE     = 2'd2,
        GRP_BAD     = 2'd3
    } grp_class_e;

    function automatic grp_class_e classify(input logic zr, input logic or_);
        case ({or_, zr})
            2'b00:   return GRP_EMPTY;
            2'b01:   return GRP_ZERO;
            2'b10:   return GRP_ONE;
            default: return GRP_BAD;
        endcase
    endfunction

    // next state of a hysteresis threshold element
    function automatic logic th_next(input int hits, input int thresh, input logic cur);
        if (hits >= thresh)
            return 1'b1;
        else if (hits == 0)
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/ncl_th_cell.sv
module ncl_th_cell #(
    parameter int M = 2,
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] in_rails,
    output logic         q
);
    import ncl_stage_pkg::*;

    int hits;

    always_comb hits = $countones(in_rails);

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else
            q <= th_next(hits, M, q);
    end
endmodule

// File: rtl/ncl_rail_reg.sv
module ncl_rail_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din_r0,
    input  logic [N-1:0] din_r1,
    input  logic         ki,
    output logic [N-1:0] dout_r0,
    output logic [N-1:0] dout_r1
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        ncl_th_cell #(.M(2), .N(2)) u_c0 (
            .clk      (clk),
            .rst      (rst),
            .in_rails ({din_r0[g], ki}),
            .q        (dout_r0[g])
        );
        ncl_th_cell #(.M(2), .N(2)) u_c1 (
            .clk      (clk),
            .rst      (rst),
            .in_rails ({din_r1[g], ki}),
            .q        (dout_r1[g])
        );
    end
endmodule

// File: rtl/ncl_completion.sv
module ncl_completion #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] grp_r0,
    input  logic [N-1:0] grp_r1,
    output logic         req_data
);
    logic [N-1:0] grp_live;
    logic         done;

    for (genvar g = 0; g < N; g++) begin : g_or
        assign grp_live[g] = grp_r0[g] | grp_r1[g];
    end

    ncl_th_cell #(.M(N), .N(N)) u_tree (
        .clk      (clk),
        .rst      (rst),
        .in_rails (grp_live),
        .q        (done)
    );

    assign req_data = ~done;
endmodule

// File: rtl/ncl_pipe_stage.sv
module ncl_pipe_stage #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din_r0,
    input  logic [N-1:0] din_r1,
    input  logic         ki,
    output logic [N-1:0] dout_r0,
    output logic [N-1:0] dout_r1,
    output logic         ko
);
    ncl_rail_reg #(.N(N)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .din_r0  (din_r0),
        .din_r1  (din_r1),
        .ki      (ki),
        .dout_r0 (dout_r0),
        .dout_r1 (dout_r1)
    );

    ncl_completion #(.N(N)) u_cd (
        .clk      (clk),
        .rst      (rst),
        .grp_r0   (dout_r0),
        .grp_r1   (dout_r1),
        .req_data (ko)
    );
endmodule

// File: rtl/ncl_pipe_stage_chk.sv
module ncl_pipe_stage_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] din_r0,
    input logic [N-1:0] din_r1,
    input logic         ki,
    input logic [N-1:0] dout_r0,
    input logic [N-1:0] dout_r1,
    input logic         ko
);
    import ncl_stage_pkg::*;

    logic all_full;
    logic all_empty;

    always_comb begin
        all_full  = 1'b1;
        all_empty = 1'b1;
        for (int i = 0; i < N; i++) begin
            grp_class_e c;
            c = classify(dout_r0[i], dout_r1[i]);
            all_full  = all_full & ((c == GRP_ZERO) || (c == GRP_ONE));
            all_empty = all_empty & (c == GRP_EMPTY);
        end
    end

    p_reset_null_r1: assert property (@(posedge clk)
        $past(rst) |-> (dout_r0 == '0 && dout_r1 == '0 && ko));

    for (genvar g = 0; g < N; g++) begin : g_rail
        p_set_one_r2: assert property (@(posedge clk) disable iff (rst)
            $rose(dout_r1[g]) |-> ($past(ki) && $past(din_r1[g])));
        p_set_zero_r2: assert property (@(posedge clk) disable iff (rst)
            $rose(dout_r0[g]) |-> ($past(ki) && $past(din_r0[g])));
        p_clear_one_r3: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $fell(dout_r1[g])) |-> (!$past(ki) && !$past(din_r1[g])));
        p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $fell(dout_r0[g])) |-> (!$past(ki) && !$past(din_r0[g])));
        p_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && ($past(ki) != $past(din_r1[g]))) |-> $stable(dout_r1[g]));
    end

    p_ko_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(ko) |-> $past(all_full));

    p_ko_rise_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(ko)) |-> $past(all_empty));
endmodule

bind ncl_pipe_stage ncl_pipe_stage_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .din_r0  (din_r0),
    .din_r1  (din_r1),
    .ki      (ki),
    .dout_r0 (dout_r0),
    .dout_r1 (dout_r1),
    .ko      (ko)
);

// File: tb/sim_ncl_pipe_stage.sv
module sim_ncl_pipe_stage;
    localparam int W  = 4;
    localparam int NW = 40;
    localparam logic [W-1:0] MASK = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   total = 0;
    int   bad   = 0;

    always #10ns clk = ~clk;

    // single stage under direct control
    logic [W-1:0] d0 = '0, d1 = '0, q0, q1;
    logic         ki0 = 1'b1, ko0;

    ncl_pipe_stage #(.N(W)) u0 (
        .clk(clk), .rst(rst), .din_r0(d0), .din_r1(d1), .ki(ki0),
        .dout_r0(q0), .dout_r1(q1), .ko(ko0)
    );

    // two-stage chain
    logic [W-1:0] s0 = '0, s1 = '0, a0, a1, b0, b1;
    logic         a_ko, b_ko, sink_ki = 1'b1;

    ncl_pipe_stage #(.N(W)) u_a (
        .clk(clk), .rst(rst), .din_r0(s0), .din_r1(s1), .ki(b_ko),
        .dout_r0(a0), .dout_r1(a1), .ko(a_ko)
    );
    ncl_pipe_stage #(.N(W)) u_b (
        .clk(clk), .rst(rst), .din_r0(a0), .din_r1(a1), .ki(sink_ki),
        .dout_r0(b0), .dout_r1(b1), .ko(b_ko)
    );

    function automatic logic [W-1:0] zero_rails(input logic [W-1:0] w);
        return ~w & MASK;
    endfunction

    function automatic logic full_word(input logic [W-1:0] r0, input logic [W-1:0] r1);
        return ((r0 ^ r1) == MASK);
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic [W-1:0] e0,
                              input logic [W-1:0] e1, input logic eko);
        total++;
        if (q0 !== e0 || q1 !== e1 || ko0 !== eko) begin
            bad++;
            $display("FAIL %s actual r0=%b r1=%b ko=%b expected r0=%b r1=%b ko=%b",
                     req, q0, q1, ko0, e0, e1, eko);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // chain monitor
    int   waves_seen = 0;
    int   alt_errs   = 0;
    int   bad_rails  = 0;
    logic seen_null  = 1'b1;
    logic in_full    = 1'b0;
    logic mon_on     = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            if ((b0 & b1) != '0) bad_rails++;
            if (b0 == '0 && b1 == '0) begin
                seen_null = 1'b1;
                in_full   = 1'b0;
            end else if (full_word(b0, b1) && !in_full) begin
                in_full = 1'b1;
                if (!seen_null) alt_errs++;
                seen_null = 1'b0;
                waves_seen++;
            end
        end
    end

    initial begin
        #(20ns * 150000);
        bad++;
        $display("FAIL R7 watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [W-1:0] w, w2;
        logic [W-1:0] sent [NW];
        logic [W-1:0] got  [NW];
        void'($urandom(32'h5eed_1234));

        repeat (3) step();
        expect_out("R1 in reset", '0, '0, 1'b1);
        rst = 1'b0;
        step();
        expect_out("R1 after reset", '0, '0, 1'b1);

        for (int it = 0; it < 20; it++) begin
            w  = $urandom & MASK;
            w2 = $urandom & MASK;
            if (it == 0) w = '0;
            if (it == 1) w = MASK;
            d1 = w; d0 = zero_rails(w); ki0 = 1'b1;
            step();
            expect_out("R2 capture", zero_rails(w), w, 1'b1);
            step();
            expect_out("R5 ko falls", zero_rails(w), w, 1'b0);
            d1 = '0; d0 = '0;
            step();
            expect_out("R4 null held off", zero_rails(w), w, 1'b0);
            ki0 = 1'b0;
            step();
            expect_out("R3 clear", '0, '0, 1'b0);
            step();
            expect_out("R6 ko rises", '0, '0, 1'b1);
            d1 = w2; d0 = zero_rails(w2);
            step();
            expect_out("R4 data held off", '0, '0, 1'b1);
            ki0 = 1'b1;
            step();
            expect_out("R2 late request", zero_rails(w2), w2, 1'b1);
            step();
            d1 = '0; d0 = '0; ki0 = 1'b0;
            step();
            step();
        end

        // partial words must not move ko
        w = $urandom & MASK;
        d1 = w & 4'b0001; d0 = zero_rails(w) & 4'b0001; ki0 = 1'b1;
        step(); step();
        expect_out("R5 partial data", zero_rails(w) & 4'b0001, w & 4'b0001, 1'b1);
        d1 = w; d0 = zero_rails(w);
        step(); step();
        expect_out("R5 completed", zero_rails(w), w, 1'b0);
        d1 = w & 4'b0001; d0 = zero_rails(w) & 4'b0001; ki0 = 1'b0;
        step(); step();
        expect_out("R6 partial null", zero_rails(w) & 4'b0001, w & 4'b0001, 1'b0);
        d1 = '0; d0 = '0;
        step(); step();
        expect_out("R6 all null", '0, '0, 1'b1);

        // chain with four-phase source and irregular sink
        mon_on = 1'b1;
        fork
            begin
                for (int n = 0; n < NW; n++) begin
                    while (a_ko !== 1'b1) @(negedge clk);
                    w = $urandom & MASK;
                    sent[n] = w;
                    s1 = w; s0 = zero_rails(w);
                    @(negedge clk);
                    while (a_ko !== 1'b0) @(negedge clk);
                    s1 = '0; s0 = '0;
                    @(negedge clk);
                end
            end
            begin
                for (int n = 0; n < NW; n++) begin
                    while (!full_word(b0, b1)) @(negedge clk);
                    got[n] = b1;
                    repeat ($urandom % 7) @(negedge clk);
                    sink_ki = 1'b0;
                    while (!(b0 == '0 && b1 == '0)) @(negedge clk);
                    repeat ($urandom % 7) @(negedge clk);
                    sink_ki = 1'b1;
                end
            end
        join
        repeat (4) step();

        for (int n = 0; n < NW; n++) begin
            total++;
            if (got[n] !== sent[n]) begin
                bad++;
                $display("FAIL R7 word %0d actual=%h expected=%h", n, got[n], sent[n]);
            end
        end
        total++;
        if (waves_seen != NW) begin
            bad++;
            $display("FAIL R7 wave count actual=%0d expected=%0d", waves_seen, NW);
        end
        total++;
        if (alt_errs != 0 || bad_rails != 0) begin
            bad++;
            $display("FAIL R7 alternation actual=%0d/%0d expected=0/0", alt_errs, bad_rails);
        end
        summary();
    end
endmodule